// File: doc/BRIEF.md
# Serial Peripheral Controller with Mode-Fault Guard

This block is an 8-bit synchronous serial port that runs either as the clock-driving master or as a selected slave. Software uses three registers, picked by a small select code. The control register turns the port on, chooses master or slave, arms fault detection and selects the clock rate. The status register reports a received byte, an empty transmit buffer and a mode fault. The data location is two separate buffers: a write fills the transmit buffer and a read returns the receive buffer.

As master, the port shifts a byte out most-significant bit first as soon as the transmit buffer is loaded. The serial clock is the system clock divided by twice a divisor. A two-bit rate code selects that divisor from the set 2, 8, 32 and 128. As slave, the port follows an external serial clock while its select input is low. A guard watches the select input while the port is master. If fault detection is armed and the select input goes low, the guard sets a sticky fault flag, drops out of master mode and stops driving the clock and data pins. The guard also reports whether the select pin is free for general-purpose use.

The state machine has six states. OFF holds while the port is disabled. M_IDLE means master with nothing to send. M_LOW and M_HIGH are the two halves of each serial clock period. S_WAIT means slave, not selected. S_SHIFT means slave, selected. The transitions are:
- Any state goes to OFF when the enable bit is 0.
- OFF goes to M_IDLE or S_WAIT, depending on the master bit.
- M_IDLE goes to M_LOW when the transmit buffer is full, and loads the shifter.
- M_LOW goes to M_HIGH at the end of a half period.
- M_HIGH goes back to M_LOW at the end of a half period, or to M_IDLE after the eighth bit.
- Any master state goes to S_WAIT when the master bit clears.
- S_WAIT goes to S_SHIFT when the select input goes low, and loads the shifter.
- S_SHIFT goes back to S_WAIT when the select input goes high.
- Either slave state goes to M_IDLE when the master bit is set.

Top module: `spi_ctl`

## Requirements
- R1: Register codes are 0 for control, 1 for status and 2 for data. Control bit 0 is enable, bit 1 is master, bit 2 is fault-detect enable, and bits 4:3 are the rate code. Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is fault. After reset the control register reads 0 and the status register reads 0x02.
- R2: In master mode, rate codes 0, 1, 2 and 3 make each half of the serial clock last 2, 8, 32 and 128 system clocks. The divider restarts when a byte is loaded, so the first low half of each byte has its full length. This low half starts on the clock after the shifter load.
- R3: In master mode, the serial clock idles low. The data output presents the byte MSB first and changes at the end of each high half. The data input is sampled at the end of each low half.
- R4: The fault flag can set only when the port is an enabled master, fault-detect enable is 1 and the synchronised select input is low. The flag sets on the third clock after the pin falls. Writing fault-detect enable to 0 does not clear a flag that is already set.
- R5: When the fault flag sets, the master bit clears and the clock and data outputs stop being driven. Any byte in progress is abandoned without setting receive-full. While the flag is set, the master bit cannot be written to 1.
- R6: A fault is cleared only by a status read made while the flag is set, followed by a control write. A control write without that earlier read leaves the flag set.
- R7: The select pin is reported free for general-purpose use when the port is disabled, or when it is an enabled master with fault-detect enable at 0. It is not free otherwise. An enabled master with fault-detect enable at 0 ignores the select level.
- R8: A data write fills the transmit buffer and clears transmit-empty. The move into the shifter sets transmit-empty again. A data read returns only the receive buffer, which a data write never changes.
- R9: Receive-full sets when a byte completes, and a data read clears it. If both happen in the same clock, the flag stays set.
- R10: As an enabled slave, the port drives its data output only while selected. It loads the shifter from the transmit buffer on selection, samples the data input on rising external clock edges and shifts on falling edges. The rate code has no effect in this mode.
- R11: While disabled, the port drives none of the clock, master-data or slave-data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider base |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register code: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; enables read side effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data in while slave |
| mosi_o | output | 1 | Serial data out while master |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in while master |
| miso_o | output | 1 | Serial data out while slave |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Select input, active low |
| ss_gpio | output | 1 | Select pin is free for general-purpose use |

## Verification
Two events can fall in the same clock: the final serial edge of a master byte sets receive-full, and a data-register read clears it. The bench raises the read strobe in exactly the clock before the last falling serial edge of a transfer at the slowest rate. It then expects the flag to stay set and the read to return the previous byte. A plain read afterwards must clear the flag. Every master clock cycle is compared with a queue of expected serial-clock and data-out levels, which the bench builds from the divisor table. The queue pins down the divider restart and the edge where each bit changes.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;

    localparam int DATA_W = 8;
    localparam int RATE_W = 2;
    localparam int DIV_W  = 7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_M_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_WAIT,
        ST_S_SHIFT
    } spi_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              fault_en;
        logic              master;
        logic              en;
    } ctrl_t;

    // Last count value of a half period: divisor 2 << (2*code), minus one.
    function automatic logic [DIV_W-1:0] half_last(input logic [RATE_W-1:0] code);
        int unsigned bd;
        bd = 32'd2 << (2 * code);
        return DIV_W'(bd - 1);
    endfunction

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_baud.sv
`timescale 1ns/1ps
module spi_baud
    import spi_pkg::*;
#(
    parameter int CW = DIV_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          tick
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last = CW'(half_last(RATE_W'(rate)));
        tick = run && (cnt_q >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (restart || !run || tick) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rate) |-> cnt_q <= last); // R2

endmodule

// File: rtl/spi_shreg.sv
`timescale 1ns/1ps
module spi_shreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          cap,
    input  logic          cap_bit,
    input  logic          shift,
    output logic [DW-1:0] q,
    output logic          rbit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            rbit <= 1'b0;
        end else begin
            if (load)       q <= load_val;
            else if (shift) q <= {q[DW-2:0], rbit};
            if (cap)        rbit <= cap_bit;
        end
    end

endmodule

// File: rtl/spi_fault.sv
`timescale 1ns/1ps
module spi_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cond,
    input  logic stat_rd,
    input  logic ctrl_wr,
    output logic fault_q,
    output logic clear_go
);

    logic armed_q;

    assign clear_go = ctrl_wr && armed_q && fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_cond)      fault_q <= 1'b1;
            else if (clear_go) fault_q <= 1'b0;

            if (!fault_q || ctrl_wr) armed_q <= 1'b0;
            else if (stat_rd)        armed_q <= 1'b1;
        end
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && !clear_go |=> fault_q); // R4
    AST_FAULT_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_q && !set_cond |=> !fault_q); // R4
    AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(armed_q)); // R6

endmodule

// File: rtl/spi_ctl.sv
`timescale 1ns/1ps
module spi_ctl
    import spi_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i,
    output logic          ss_gpio
);

    localparam int BIT_CW = $clog2(DW);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DW - 1);

    spi_state_e state_q, state_d;
    ctrl_t      ctrl_q;
    logic [DW-1:0] tx_buf_q, rx_buf_q, rx_next, sh_q;
    logic       tx_empty_q, rx_full_q;
    logic [BIT_CW-1:0] bit_cnt_q;
    logic       last_bit;
    logic       ss_s, sck_s, mosi_s, sck_prev_q;
    logic       sck_rise, sck_fall;
    logic       wr_ctrl, wr_data, rd_stat, rd_data;
    logic       set_cond, fault_q, clear_go;
    logic       tick, load, m_rise, m_fall, s_cap, s_shift, cap, cap_bit, shift;
    logic       m_done, s_done, byte_done, rbit;

    // ---------------- input synchronisers ----------------
    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i}),
        .q     ({ss_s, sck_s, mosi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    assign sck_rise = sck_s && !sck_prev_q;
    assign sck_fall = !sck_s && sck_prev_q;

    // ---------------- register strobes ----------------
    always_comb begin
        wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
        wr_data = reg_wr && (reg_sel == SEL_DATA);
        rd_stat = reg_rd && (reg_sel == SEL_STAT);
        rd_data = reg_rd && (reg_sel == SEL_DATA);
    end

    // ---------------- fault guard ----------------
    assign set_cond = ctrl_q.en && ctrl_q.master && ctrl_q.fault_en && !ss_s;

    spi_fault u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_cond (set_cond),
        .stat_rd  (rd_stat),
        .ctrl_wr  (wr_ctrl),
        .fault_q  (fault_q),
        .clear_go (clear_go)
    );

    // ---------------- control register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en       <= reg_wdata[0];
                ctrl_q.master   <= reg_wdata[1] && (!fault_q || clear_go);
                ctrl_q.fault_en <= reg_wdata[2];
                ctrl_q.rate     <= reg_wdata[4:3];
            end
            if (set_cond) ctrl_q.master <= 1'b0;
        end
    end

    // ---------------- clock divider ----------------
    spi_baud #(.CW(DIV_W), .RW(RATE_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     ((state_q == ST_M_LOW) || (state_q == ST_M_HIGH)),
        .rate    (ctrl_q.rate),
        .tick    (tick)
    );

    assign last_bit = (bit_cnt_q == LAST_BIT);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (!ctrl_q.en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ctrl_q.master ? ST_M_IDLE : ST_S_WAIT;
                ST_M_IDLE: begin
                    if (!ctrl_q.master)  state_d = ST_S_WAIT;
                    else if (!tx_empty_q) state_d = ST_M_LOW;
                end
                ST_M_LOW: begin
                    if (!ctrl_q.master) state_d = ST_S_WAIT;
                    else if (tick)      state_d = ST_M_HIGH;
                end
                ST_M_HIGH: begin
                    if (!ctrl_q.master) state_d = ST_S_WAIT;
                    else if (tick)      state_d = last_bit ? ST_M_IDLE : ST_M_LOW;
                end
                ST_S_WAIT: begin
                    if (ctrl_q.master) state_d = ST_M_IDLE;
                    else if (!ss_s)    state_d = ST_S_SHIFT;
                end
                ST_S_SHIFT: begin
                    if (ctrl_q.master) state_d = ST_M_IDLE;
                    else if (ss_s)     state_d = ST_S_WAIT;
                end
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // ---------------- datapath controls and pins ----------------
    always_comb begin
        load    = ((state_q == ST_M_IDLE) && (state_d == ST_M_LOW)) ||
                  ((state_q == ST_S_WAIT) && (state_d == ST_S_SHIFT));
        m_rise  = (state_q == ST_M_LOW) && (state_d == ST_M_HIGH);
        m_fall  = (state_q == ST_M_HIGH) &&
                  ((state_d == ST_M_LOW) || (state_d == ST_M_IDLE));
        s_cap   = (state_q == ST_S_SHIFT) && (state_d == ST_S_SHIFT) && sck_rise;
        s_shift = (state_q == ST_S_SHIFT) && (state_d == ST_S_SHIFT) && sck_fall;
        cap     = m_rise || s_cap;
        cap_bit = (state_q == ST_M_LOW) ? miso_i : mosi_s;
        shift   = m_fall || s_shift;
        m_done  = m_fall && last_bit;
        s_done  = s_cap && last_bit;
        byte_done = m_done || s_done;
        rx_next = s_done ? {sh_q[DW-2:0], mosi_s} : {sh_q[DW-2:0], rbit};

        sck_o   = (state_q == ST_M_HIGH);
        sck_oe  = ctrl_q.en && ctrl_q.master;
        mosi_o  = sh_q[DW-1];
        mosi_oe = ctrl_q.en && ctrl_q.master;
        miso_o  = sh_q[DW-1];
        miso_oe = ctrl_q.en && !ctrl_q.master && (state_q == ST_S_SHIFT);
        ss_gpio = !ctrl_q.en || (ctrl_q.master && !ctrl_q.fault_en);

        unique case (reg_sel)
            SEL_CTRL: reg_rdata = DW'(ctrl_q);
            SEL_STAT: reg_rdata = DW'({fault_q, tx_empty_q, rx_full_q});
            SEL_DATA: reg_rdata = rx_buf_q;
            default:  reg_rdata = '0;
        endcase
    end

    spi_shreg #(.DW(DW)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (tx_buf_q),
        .cap      (cap),
        .cap_bit  (cap_bit),
        .shift    (shift),
        .q        (sh_q),
        .rbit     (rbit)
    );

    // ---------------- bit counter and flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            tx_empty_q <= 1'b1;
            rx_full_q  <= 1'b0;
        end else begin
            if (load)                 bit_cnt_q <= '0;
            else if (m_fall || s_cap) bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;

            if (wr_data)   tx_empty_q <= 1'b0;
            else if (load) tx_empty_q <= 1'b1;

            if (byte_done)    rx_full_q <= 1'b1;
            else if (rd_data) rx_full_q <= 1'b0;
        end
    end

    // Buffers carry no reset; their contents are undefined until written.
    always_ff @(posedge clk) begin
        if (wr_data)   tx_buf_q <= reg_wdata;
        if (byte_done) rx_buf_q <= rx_next;
    end

    AST_NO_DRIVE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> !sck_oe && !mosi_oe); // R5
    AST_SLAVE_OWNS_SS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.en && !ctrl_q.master |-> !ss_gpio); // R7
    AST_ONE_DATA_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe)); // R10
    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> rx_full_q); // R9
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> !sck_oe && !mosi_oe && !miso_oe); // R11

endmodule

// File: tb/tb_spi_ctl.sv
`timescale 1ns/1ps
module tb_spi_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_gpio;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  exp_sck_q[$];
    bit  exp_mosi_q[$];
    bit  es, em;

    always #4 clk = ~clk;

    spi_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i),
        .ss_gpio(ss_gpio)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-cycle reference comparison of the master serial pins.
    always @(negedge clk) begin
        if (exp_sck_q.size() > 0) begin
            es = exp_sck_q.pop_front();
            em = exp_mosi_q.pop_front();
            chk("R2 sck level", int'(sck_o), int'(es));
            chk("R3 mosi level", int'(mosi_o), int'(em));
        end
    end

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_byte(input logic [7:0] tx, input logic [7:0] mb, input int code,
                               input bit collide, input logic [7:0] prev);
        int bd;
        logic [7:0] v, old;
        bd = 2 << (2 * code);
        old = 8'h00;
        wr(2'd2, tx);
        peek(2'd1, v); chk("R8 tx_empty cleared by write", int'(v[1]), 0);
        #1;
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < bd; k++) begin exp_sck_q.push_back(1'b0); exp_mosi_q.push_back(tx[7-i]); end
            for (int k = 0; k < bd; k++) begin exp_sck_q.push_back(1'b1); exp_mosi_q.push_back(tx[7-i]); end
        end
        @(negedge clk);
        peek(2'd1, v); chk("R8 tx_empty set by load", int'(v[1]), 1);
        for (int i = 0; i < 8; i++) begin
            miso_i = mb[7-i];
            if (collide && i == 7) begin
                repeat (2 * bd - 1) @(negedge clk);
                reg_sel = 2'd2; reg_rd = 1'b1;
                #1 old = reg_rdata;
                @(negedge clk);
                reg_rd = 1'b0;
            end else begin
                repeat (2 * bd) @(negedge clk);
            end
        end
        peek(2'd1, v); chk("R9 rx_full after byte", int'(v[0]), 1);
        chk("R3 sck idles low", int'(sck_o), 0);
        if (collide) chk("R9 colliding read returns previous byte", int'(old), int'(prev));
        rd(2'd2, v); chk("R3 received byte MSB first", int'(v), int'(mb));
        peek(2'd1, v); chk("R9 data read clears rx_full", int'(v[0]), 0);
    endtask

    task automatic slave_byte(input logic [7:0] tx, input logic [7:0] mb);
        logic [7:0] v;
        wr(2'd2, tx);
        chk("R10 miso idle before select", int'(miso_oe), 0);
        ss_n_i = 1'b0;
        idle(4);
        chk("R10 miso driven when selected", int'(miso_oe), 1);
        chk("R10 master pins quiet in slave", int'(sck_oe) + int'(mosi_oe), 0);
        peek(2'd1, v); chk("R8 slave load sets tx_empty", int'(v[1]), 1);
        for (int i = 0; i < 8; i++) begin
            mosi_i = mb[7-i];
            idle(4);
            chk("R10 slave output bit", int'(miso_o), int'(tx[7-i]));
            sck_i = 1'b1; idle(4);
            sck_i = 1'b0; idle(4);
        end
        peek(2'd1, v); chk("R10 slave byte complete", int'(v[0]), 1);
        rd(2'd2, v); chk("R10 slave received byte", int'(v), int'(mb));
        ss_n_i = 1'b1;
        idle(4);
        chk("R10 miso released after deselect", int'(miso_oe), 0);
    endtask

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        peek(2'd0, v); chk("R1 control reset value", int'(v), 0);
        peek(2'd1, v); chk("R1 status reset value", int'(v), 2);
        chk("R11 no pin driven when disabled", int'(sck_oe) + int'(mosi_oe) + int'(miso_oe), 0);
        chk("R7 pin free when disabled", int'(ss_gpio), 1);

        // Master, fault detect off, code 0.
        wr(2'd0, 8'h03);
        idle(2);
        chk("R7 pin free for master without fault detect", int'(ss_gpio), 1);
        chk("R3 sck idles low in master", int'(sck_o), 0);
        master_byte(8'hA5, 8'h3C, 0, 1'b0, 8'h00);

        // Code 1 with the select pin low: must be ignored.
        wr(2'd0, 8'h0B);
        peek(2'd0, v); chk("R1 rate field readback", int'(v[4:3]), 1);
        ss_n_i = 1'b0;
        master_byte(8'h5A, 8'hC3, 1, 1'b0, 8'h00);
        peek(2'd1, v); chk("R7 select level ignored, no fault", int'(v[2]), 0);
        ss_n_i = 1'b1;
        idle(4);

        // Code 3, read collides with byte completion.
        wr(2'd0, 8'h1B);
        master_byte(8'h81, 8'h7E, 3, 1'b1, 8'hC3);

        // Code 2 with fault detect on.
        wr(2'd0, 8'h17);
        idle(1);
        chk("R7 pin owned with fault detect", int'(ss_gpio), 0);
        master_byte(8'h96, 8'h69, 2, 1'b0, 8'h00);

        // Fault during a transfer.
        wr(2'd2, 8'hFF);
        idle(20);
        ss_n_i = 1'b0;
        idle(2);
        peek(2'd1, v); chk("R4 fault not yet set", int'(v[2]), 0);
        idle(1);
        peek(2'd1, v); chk("R4 fault set on third clock", int'(v[2]), 1);
        chk("R5 clock and data released", int'(sck_oe) + int'(mosi_oe), 0);
        peek(2'd0, v); chk("R5 master bit cleared", int'(v[1]), 0);
        idle(40);
        peek(2'd1, v); chk("R5 aborted byte not received", int'(v[0]), 0);
        ss_n_i = 1'b1;
        idle(4);
        wr(2'd0, 8'h13);
        peek(2'd1, v); chk("R4 clearing enable keeps fault", int'(v[2]), 1);
        chk("R6 write without read keeps fault", int'(v[2]), 1);
        peek(2'd0, v); chk("R5 master not writable in fault", int'(v[1]), 0);
        chk("R7 slave owns the pin", int'(ss_gpio), 0);
        rd(2'd1, v); chk("R6 status read shows fault", int'(v[2]), 1);
        wr(2'd0, 8'h17);
        peek(2'd1, v); chk("R6 read then write clears fault", int'(v[2]), 0);
        peek(2'd0, v); chk("R6 master restored", int'(v[1]), 1);

        // Slave with fault detect on and the slowest rate code.
        wr(2'd0, 8'h1D);
        idle(1);
        chk("R7 slave owns pin", int'(ss_gpio), 0);
        slave_byte(8'hD2, 8'h4B);
        wr(2'd2, 8'h11);
        rd(2'd2, v); chk("R8 buffers independent", int'(v), 8'h4B);
        peek(2'd1, v); chk("R8 pending write shows not empty", int'(v[1]), 0);

        wr(2'd0, 8'h00);
        idle(1);
        chk("R11 disabled outputs quiet", int'(sck_oe) + int'(mosi_oe) + int'(miso_oe), 0);
        chk("R7 disabled releases pin", int'(ss_gpio), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule